// File: doc/BRIEF.md
# Serial Double-Buffered DAC Register Front End

This block receives 24-bit command frames over a three-wire serial link (active-low select, serial clock, serial data) and maintains the two registers that feed a single-channel converter. The first is a holding register that software writes. The second is an output latch whose contents drive the converter's parallel input. A four-bit opcode at the head of each frame selects one of three actions: write the holding register, copy the holding register into the output latch, or write both at once.

Two side pins work alongside the serial path. An active-low load pin makes the output latch follow the holding register for as long as it is held low. An active-high clear pin forces both registers to zero and keeps them there while it is asserted, so any command that arrives during that time has no effect. The converter resolution is a parameter and may be 8, 10 or 12 bits. All serial inputs are oversampled in the system clock domain.

Top module: `dac_serial_ctl`

## Requirements
- R1: A frame executes only when the select pin rises after exactly 24 serial clock rising edges. Bits are taken MSB first, and bits 23..20 hold the opcode.
- R2: A frame with 23 or with 25 clock edges is discarded, and neither register changes.
- R3: Opcode 4'b1000 loads the data field into the holding register. When the load pin is high, the output latch is left unchanged.
- R4: While the load pin is low, an opcode 4'b1000 write also reaches the output latch.
- R5: Opcode 4'b1001 copies the current holding register into the output latch. The holding register is not changed.
- R6: Opcodes 4'b1010 and 4'b1011 each write the data field into both registers in the same cycle.
- R7: While clear is high, both registers read zero and every command is ignored. After clear is released they stay at zero until the next command.
- R8: The data field is left-justified. For a width of N, frame bits 15 down to 16-N carry the value MSB first, and the bits below 16-N have no effect.
- R9: When the load pin goes low, the output latch takes the holding register value within SYNC_STAGES+1 system clocks and follows it while the pin stays low.
- R10: Any other opcode leaves both registers unchanged.
- R11: After reset both registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_sel_n | input | 1 | Frame select, active low |
| ser_clk | input | 1 | Serial bit clock; data is sampled on its rising edge |
| ser_din | input | 1 | Serial data, MSB first |
| load_n | input | 1 | Level-sensitive active-low transfer of the holding register to the output latch |
| clear | input | 1 | Asynchronous active-high clear of both registers |
| hold_code | output | DATA_W | Holding register contents |
| dac_code | output | DATA_W | Output latch driving the converter input |

## Verification
A command takes effect SYNC_STAGES+2 system clocks after the select pin rises: the synchronizer adds SYNC_STAGES, the frame strobe adds one, and the register update adds one. The bench waits ten clocks after each frame before it samples, and it samples at the falling clock edge. A load pin edge reaches the output latch SYNC_STAGES+1 clocks later, so the bench checks six clocks after it drives the pin. Clear acts immediately and is checked on the next falling edge. The sweep sends every opcode with the load pin high and then again with it low, and compares both registers with a model that the bench computes.

// File: rtl/dac_serial_pkg.sv
package dac_serial_pkg;
   localparam int FRAME_BITS = 24;
   localparam int OPC_W      = 4;
   localparam int FIELD_MSB  = 15;

   typedef enum logic [OPC_W-1:0] {
      OPC_HOLD_WR = 4'b1000,
      OPC_XFER    = 4'b1001,
      OPC_BOTH_A  = 4'b1010,
      OPC_BOTH_B  = 4'b1011
   } opc_e;

   function automatic bit width_ok(int w);
      return (w == 8) || (w == 10) || (w == 12);
   endfunction
endpackage

// File: rtl/dsc_sync.sv
module dsc_sync #(
   parameter int          WIDTH   = 1,
   parameter int          STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("dsc_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= RST_VAL;
         else if (s == 0) chain[s] <= din;
         else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/dsc_frame_rx.sv
module dsc_frame_rx
   import dac_serial_pkg::*;
#(
   parameter int DATA_W      = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_n,
   input  logic              sclk,
   input  logic              sdin,
   output logic              frm_vld,
   output logic [OPC_W-1:0]  frm_opc,
   output logic [DATA_W-1:0] frm_data
);
   localparam int CNT_MAX = FRAME_BITS + 1;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);

   logic [2:0] pins_s;
   logic       sel_s, sclk_s, sdin_s;
   logic       sel_d, sclk_d;
   logic       bit_stb, end_stb;
   logic [FRAME_BITS-1:0] shreg;
   logic [CNT_W-1:0]      bit_cnt;

   dsc_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_pin_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({sel_n, sclk, sdin}),
      .dout (pins_s)
   );
   assign {sel_s, sclk_s, sdin_s} = pins_s;

   assign bit_stb = sclk_s & ~sclk_d & ~sel_s;
   assign end_stb = sel_s & ~sel_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_d    <= 1'b1;
         sclk_d   <= 1'b0;
         shreg    <= '0;
         bit_cnt  <= '0;
         frm_vld  <= 1'b0;
         frm_opc  <= '0;
         frm_data <= '0;
      end else begin
         sel_d   <= sel_s;
         sclk_d  <= sclk_s;
         frm_vld <= 1'b0;
         if (bit_stb) begin
            shreg <= {shreg[FRAME_BITS-2:0], sdin_s};
            if (bit_cnt != CNT_W'(CNT_MAX)) bit_cnt <= bit_cnt + 1'b1;
         end
         if (end_stb) begin
            frm_vld  <= (bit_cnt == CNT_W'(FRAME_BITS));
            frm_opc  <= shreg[FRAME_BITS-1 -: OPC_W];
            frm_data <= shreg[FIELD_MSB -: DATA_W];
            bit_cnt  <= '0;
         end
      end
   end

   // R1: a frame strobe lasts a single cycle
   assert_vld_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
      frm_vld |=> !frm_vld);
endmodule

// File: rtl/dsc_dac_regs.sv
module dsc_dac_regs
   import dac_serial_pkg::*;
#(
   parameter int DATA_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              load_n_s,
   input  logic              cmd_vld,
   input  logic [OPC_W-1:0]  cmd_opc,
   input  logic [DATA_W-1:0] cmd_data,
   output logic [DATA_W-1:0] hold_q,
   output logic [DATA_W-1:0] dac_q
);
   logic              arst_n;
   logic [DATA_W-1:0] hold_nx, dac_nx;

   assign arst_n = rst_n & ~clear;

   always_comb begin
      hold_nx = hold_q;
      dac_nx  = dac_q;
      if (cmd_vld) begin
         case (cmd_opc)
            OPC_HOLD_WR:           hold_nx = cmd_data;
            OPC_XFER:              dac_nx  = hold_q;
            OPC_BOTH_A, OPC_BOTH_B: begin
               hold_nx = cmd_data;
               dac_nx  = cmd_data;
            end
            default: ;
         endcase
      end
      if (!load_n_s) dac_nx = hold_nx;
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         hold_q <= '0;
         dac_q  <= '0;
      end else begin
         hold_q <= hold_nx;
         dac_q  <= dac_nx;
      end
   end

   assert_hold_only_R3: assert property (@(posedge clk) disable iff (!rst_n || clear)
      (cmd_vld && cmd_opc == OPC_HOLD_WR && load_n_s) |=> $stable(dac_q));
   assert_hold_through_R4: assert property (@(posedge clk) disable iff (!rst_n || clear)
      (cmd_vld && cmd_opc == OPC_HOLD_WR && !load_n_s) |=> (dac_q == $past(cmd_data)));
   assert_xfer_R5: assert property (@(posedge clk) disable iff (!rst_n || clear)
      (cmd_vld && cmd_opc == OPC_XFER) |=> (dac_q == $past(hold_q)) && $stable(hold_q));
   assert_both_R6: assert property (@(posedge clk) disable iff (!rst_n || clear)
      (cmd_vld && cmd_opc[3:1] == 3'b101) |=> (dac_q == hold_q) && (hold_q == $past(cmd_data)));
   assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      clear |-> (hold_q == '0) && (dac_q == '0));
   assert_pin_follow_R9: assert property (@(posedge clk) disable iff (!rst_n || clear)
      !load_n_s |=> (dac_q == hold_q));
   assert_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n || clear)
      (cmd_vld && cmd_opc[3:2] != 2'b10) |=> $stable(hold_q));
endmodule

// File: rtl/dac_serial_ctl.sv
module dac_serial_ctl
   import dac_serial_pkg::*;
#(
   parameter int DATA_W      = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_sel_n,
   input  logic              ser_clk,
   input  logic              ser_din,
   input  logic              load_n,
   input  logic              clear,
   output logic [DATA_W-1:0] hold_code,
   output logic [DATA_W-1:0] dac_code
);
   if (!width_ok(DATA_W)) begin : g_bad_width
      $error("dac_serial_ctl: DATA_W must be 8, 10 or 12");
   end

   logic              frm_vld;
   logic [OPC_W-1:0]  frm_opc;
   logic [DATA_W-1:0] frm_data;
   logic              load_n_s;

   dsc_frame_rx #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel_n   (ser_sel_n),
      .sclk    (ser_clk),
      .sdin    (ser_din),
      .frm_vld (frm_vld),
      .frm_opc (frm_opc),
      .frm_data(frm_data)
   );

   dsc_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_load_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (load_n),
      .dout (load_n_s)
   );

   dsc_dac_regs #(.DATA_W(DATA_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (clear),
      .load_n_s(load_n_s),
      .cmd_vld (frm_vld),
      .cmd_opc (frm_opc),
      .cmd_data(frm_data),
      .hold_q  (hold_code),
      .dac_q   (dac_code)
   );

   // R8: the holding register takes the left-justified field of a write frame
   assert_field_R8: assert property (@(posedge clk) disable iff (!rst_n || clear)
      (frm_vld && frm_opc == OPC_HOLD_WR) |=> (hold_code == $past(frm_data)));
endmodule

// File: tb/dac_serial_ctl_tb_top.sv
`timescale 1ns/1ps
module dac_serial_ctl_tb_top;
   localparam int W    = 12;
   localparam int LSB  = 16 - W;
   localparam int MASK = (1 << W) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sel_n = 1'b1, sclk = 1'b0, sdin = 1'b0, load_n = 1'b1, clear = 1'b0;
   logic [W-1:0] hold_code, dac_code;

   int total = 0;
   int bad   = 0;
   bit finished = 1'b0;
   int m_hold = 0, m_dac = 0;

   always #5 clk = ~clk;

   dac_serial_ctl #(.DATA_W(W), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .ser_sel_n(sel_n), .ser_clk(sclk), .ser_din(sdin),
      .load_n(load_n), .clear(clear), .hold_code(hold_code), .dac_code(dac_code)
   );

   task automatic chk(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send(logic [23:0] frm, int nbits);
      @(negedge clk); sel_n = 1'b0;
      idle(4);
      for (int i = 0; i < nbits; i++) begin
         sdin = (i < 24) ? frm[23-i] : 1'b0;
         sclk = 1'b0; idle(4);
         sclk = 1'b1; idle(4);
      end
      sclk = 1'b0; idle(4);
      sel_n = 1'b1;
      idle(10);
   endtask

   function automatic logic [23:0] mk(int opc, int val, int junk);
      logic [23:0] f;
      f = '0;
      f[23:20] = 4'(opc);
      f[19:16] = 4'hA;
      f[15 -: W] = W'(val);
      f[LSB-1:0] = LSB'(junk);
      return f;
   endfunction

   // bench model of a command
   task automatic model(int opc, int val);
      if (opc == 8) m_hold = val & MASK;
      else if (opc == 9) m_dac = m_hold;
      else if (opc == 10 || opc == 11) begin m_hold = val & MASK; m_dac = m_hold; end
      if (!load_n) m_dac = m_hold;
   endtask

   initial begin
      idle(3);
      chk("R11 hold reset", hold_code, 0);
      chk("R11 dac reset", dac_code, 0);
      rst_n = 1'b1;
      idle(4);

      // R1 R3 R5 R6 R10: every opcode, load pin high
      for (int op = 0; op < 16; op++) begin
         int v;
         v = (op * 317 + 91) & MASK;
         send(mk(op, v, op), 24);
         model(op, v);
         chk($sformatf("R1/R3/R5/R6/R10 hold op=%0d", op), hold_code, m_hold);
         chk($sformatf("R1/R3/R5/R6/R10 dac op=%0d", op), dac_code, m_dac);
      end

      // R3 explicit: write holding only, then software transfer (R5)
      send(mk(4'b1000, 12'h5A3, 0), 24); model(8, 12'h5A3);
      chk("R3 dac unchanged", dac_code, m_dac);
      chk("R3 hold written", hold_code, 12'h5A3);
      send(mk(4'b1001, 12'hFFF, 0), 24); model(9, 12'hFFF);
      chk("R5 transfer", dac_code, 12'h5A3);
      chk("R5 hold kept", hold_code, 12'h5A3);

      // R2: short and long frames discarded
      send(mk(4'b1010, 12'h111, 0), 23);
      chk("R2 short hold", hold_code, m_hold);
      chk("R2 short dac", dac_code, m_dac);
      send(mk(4'b1010, 12'h222, 0), 25);
      chk("R2 long hold", hold_code, m_hold);
      chk("R2 long dac", dac_code, m_dac);

      // R8: low don't-care bits have no effect
      send(mk(4'b1011, 12'h0C3, 15), 24); model(11, 12'h0C3);
      chk("R8 junk bits", dac_code, 12'h0C3);
      send(mk(4'b1011, 12'h801, 0), 24); model(11, 12'h801);
      chk("R8 msb/lsb", hold_code, 12'h801);

      // R9: hardware load level
      send(mk(4'b1000, 12'h3C7, 0), 24); model(8, 12'h3C7);
      chk("R9 before pin", dac_code, 12'h801);
      @(negedge clk); load_n = 1'b0;
      idle(6); m_dac = m_hold;
      chk("R9 pin transfer", dac_code, 12'h3C7);

      // R4 and sweep with the pin held low
      for (int op = 0; op < 16; op++) begin
         int v;
         v = (op * 733 + 5) & MASK;
         send(mk(op, v, 3), 24);
         model(op, v);
         chk($sformatf("R4/R10 hold op=%0d load low", op), hold_code, m_hold);
         chk($sformatf("R4/R10 dac op=%0d load low", op), dac_code, m_dac);
      end
      @(negedge clk); load_n = 1'b1;
      idle(6);

      // R7: clear
      send(mk(4'b1010, 12'h9E1, 0), 24); model(10, 12'h9E1);
      chk("R7 setup", dac_code, 12'h9E1);
      @(negedge clk); clear = 1'b1;
      @(negedge clk);
      chk("R7 hold cleared", hold_code, 0);
      chk("R7 dac cleared", dac_code, 0);
      send(mk(4'b1011, 12'h777, 0), 24);
      chk("R7 ignored hold", hold_code, 0);
      chk("R7 ignored dac", dac_code, 0);
      clear = 1'b0;
      idle(6);
      m_hold = 0; m_dac = 0;
      chk("R7 after release hold", hold_code, 0);
      chk("R7 after release dac", dac_code, 0);
      send(mk(4'b1001, 0, 0), 24); model(9, 0);
      chk("R7 transfer after release", dac_code, 0);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule